// File: doc/BRIEF.md
# Masked Interrupt Register Group

This block is the interrupt corner of a clock and reset controller's register space. It keeps a status register, one bit per interrupt source, that hardware event inputs set and that software clears by writing ones. A mask register decides which pending status bits reach a single level-sensitive interrupt output. Software never writes the mask directly. Two strobe addresses change it instead: a write to the enable address clears the mask bits that are 1 in the data (unmasking those sources), and a write to the disable address sets them.

The block sits on a single-cycle 32-bit register port. A write happens on the rising clock edge where the write strobe is high. Read data is a combinational function of the address. Only full-word accesses on word-aligned addresses take effect. The interrupt output is registered, so it follows a change in status or mask one clock later.

Top module: `clkrst_irq_regs`

## Requirements
- R1: After reset the status register reads 0, the mask register reads all ones in its NUM_SRC low bits (every source masked), and irq_out is 0.
- R2: irq_out is a registered copy of (status AND NOT mask). It rises or falls on the clock edge after the edge that changed status or mask.
- R3: A full-word write to the status address (byte offset 0x00) clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: A high evt_in[i] sampled at a clock edge sets status bit i on that edge. If the same edge carries a write of 1 to that bit, the set wins.
- R5: The mask address (byte offset 0x04) is read-only; writes to it leave the mask unchanged.
- R6: A full-word write to the enable address (byte offset 0x08) clears each mask bit whose data bit is 1 and keeps the others.
- R7: A full-word write to the disable address (byte offset 0x0C) sets each mask bit whose data bit is 1 and keeps the others.
- R8: Reads of the enable and disable addresses always return 0.
- R9: A write with reg_be not equal to 4'hF changes no state.
- R10: A write to an address whose two low bits are nonzero, or whose word index is above 3, changes no state, and a read of such an address returns 0.
- R11: Status and mask read back in bits [NUM_SRC-1:0] of reg_rdata, with every upper bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wr | input | 1 | Write strobe, acted on at the rising edge |
| reg_be | input | 4 | Byte enables; a write needs all four set |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| evt_in | input | NUM_SRC | Hardware events; each sets its status bit |
| irq_out | output | 1 | Registered level interrupt |

## Verification
The assertions check on every cycle that irq_out follows the unmasked pending state one edge later, that the enable and disable strobes act bit by bit on the mask, that the mask holds without a strobe, that events set their status bits even against a clear, and that partial writes leave state unchanged. Only the bench's scenarios show the full address map as seen from the bus. That covers the read-back values, that writes to the mask address are ignored, that misaligned and out-of-range addresses do nothing, and the exact cycle counts in a sequence of unmask, event, mask and clear operations.

// File: rtl/clkrst_irq_pkg.sv
package clkrst_irq_pkg;

  localparam int REG_W = 32;
  localparam int BE_W  = REG_W / 8;

  // Byte offsets of the four words; the bus decodes on these.
  localparam logic [REG_W-1:0] OFS_STATUS  = 32'h0000_0000;
  localparam logic [REG_W-1:0] OFS_MASK    = 32'h0000_0004;
  localparam logic [REG_W-1:0] OFS_ENABLE  = 32'h0000_0008;
  localparam logic [REG_W-1:0] OFS_DISABLE = 32'h0000_000C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STATUS,
    SEL_MASK,
    SEL_ENABLE,
    SEL_DISABLE
  } reg_sel_e;

  // Map a byte address to a register; misaligned or unmapped gives SEL_NONE.
  function automatic reg_sel_e decode_word(input logic [REG_W-1:0] byte_addr);
    reg_sel_e sel;
    unique case (byte_addr)
      OFS_STATUS:  sel = SEL_STATUS;
      OFS_MASK:    sel = SEL_MASK;
      OFS_ENABLE:  sel = SEL_ENABLE;
      OFS_DISABLE: sel = SEL_DISABLE;
      default:     sel = SEL_NONE;
    endcase
    return sel;
  endfunction

  // A write counts only when every byte lane is enabled.
  function automatic logic full_word(input logic [BE_W-1:0] be);
    return &be;
  endfunction

  // Next value of one status bit: a hardware set takes priority over a clear.
  function automatic logic status_bit_next(input logic cur,
                                           input logic clr,
                                           input logic set);
    logic nxt;
    if (set)      nxt = 1'b1;
    else if (clr) nxt = 1'b0;
    else          nxt = cur;
    return nxt;
  endfunction

  // Bits of the interrupt view that are pending and not masked.
  function automatic logic [REG_W-1:0] unmasked(input logic [REG_W-1:0] status,
                                                input logic [REG_W-1:0] mask);
    return status & ~mask;
  endfunction

endpackage

// File: rtl/irqgrp_decode.sv
module irqgrp_decode
  import clkrst_irq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [BE_W-1:0]   be,
  output reg_sel_e          sel,
  output logic              wr_status,
  output logic              wr_enable,
  output logic              wr_disable
);

  logic wr_ok;

  always_comb begin
    sel = decode_word(REG_W'(addr));
  end

  assign wr_ok      = wr && full_word(be);
  assign wr_status  = wr_ok && (sel == SEL_STATUS);
  assign wr_enable  = wr_ok && (sel == SEL_ENABLE);
  assign wr_disable = wr_ok && (sel == SEL_DISABLE);

endmodule

// File: rtl/irqgrp_status.sv
module irqgrp_status
  import clkrst_irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_stb,
  input  logic [NUM_SRC-1:0] clr_bits,
  input  logic [NUM_SRC-1:0] set_bits,
  output logic [NUM_SRC-1:0] status
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status[i] <= 1'b0;
      end else begin
        status[i] <= status_bit_next(status[i], clr_stb && clr_bits[i], set_bits[i]);
      end
    end
  end

endmodule

// File: rtl/irqgrp_mask.sv
module irqgrp_mask #(
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               unmask_stb,
  input  logic               mask_stb,
  input  logic [NUM_SRC-1:0] bits,
  output logic [NUM_SRC-1:0] mask
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (unmask_stb) begin
      mask <= mask & ~bits;
    end else if (mask_stb) begin
      mask <= mask | bits;
    end
  end

endmodule

// File: rtl/clkrst_irq_regs.sv
module clkrst_irq_regs
  import clkrst_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [3:0]         reg_be,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] evt_in,
  output logic               irq_out
);

  // Named internal events, visible to the bound checker.
  reg_sel_e           sel_w;
  logic               wr_status_w;
  logic               wr_enable_w;
  logic               wr_disable_w;
  logic [NUM_SRC-1:0] wdata_lo_w;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               pending_w;
  logic               irq_q;
  logic               unused_w;

  assign wdata_lo_w = reg_wdata[NUM_SRC-1:0];
  assign unused_w   = ^reg_wdata[REG_W-1:NUM_SRC];

  irqgrp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr       (reg_addr),
    .wr         (reg_wr),
    .be         (reg_be),
    .sel        (sel_w),
    .wr_status  (wr_status_w),
    .wr_enable  (wr_enable_w),
    .wr_disable (wr_disable_w)
  );

  irqgrp_status #(.NUM_SRC(NUM_SRC)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_stb  (wr_status_w),
    .clr_bits (wdata_lo_w),
    .set_bits (evt_in),
    .status   (status_q)
  );

  irqgrp_mask #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .unmask_stb (wr_enable_w),
    .mask_stb   (wr_disable_w),
    .bits       (wdata_lo_w),
    .mask       (mask_q)
  );

  assign pending_w = |unmasked(REG_W'(status_q), REG_W'(mask_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending_w;
  end

  assign irq_out = irq_q;

  // Read mux: the strobe words and unmapped addresses return zero.
  always_comb begin
    unique case (sel_w)
      SEL_STATUS: reg_rdata = REG_W'(status_q);
      SEL_MASK:   reg_rdata = REG_W'(mask_q);
      default:    reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/clkrst_irq_regs_chk.sv
module clkrst_irq_regs_chk
  import clkrst_irq_pkg::*;
#(
  parameter int NUM_SRC = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic [3:0]         reg_be,
  input logic [31:0]        reg_rdata,
  input logic [NUM_SRC-1:0] evt_in,
  input logic               irq_out,
  input reg_sel_e           sel_w,
  input logic               wr_status_w,
  input logic               wr_enable_w,
  input logic               wr_disable_w,
  input logic [NUM_SRC-1:0] wdata_lo_w,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] mask_q
);

  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (status_q == '0 && mask_q == '1 && !irq_out));

  p_irq_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) != '0) |=> irq_out);

  p_irq_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & ~mask_q) == '0) |=> !irq_out);

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status_w |=> ((status_q & $past(wdata_lo_w & ~evt_in)) == '0));

  p_evt_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((status_q & $past(evt_in)) == $past(evt_in)));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_enable_w && !wr_disable_w) |=> $stable(mask_q));

  p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable_w |=> ((mask_q & $past(wdata_lo_w)) == '0) &&
                    ((mask_q | $past(wdata_lo_w)) == ($past(mask_q) | $past(wdata_lo_w))));

  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disable_w |=> (mask_q == ($past(mask_q) | $past(wdata_lo_w))));

  p_strobe_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w == SEL_ENABLE || sel_w == SEL_DISABLE) |-> (reg_rdata == '0));

  p_partial_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !(&reg_be) && evt_in == '0) |=>
      (status_q == $past(status_q)) && (mask_q == $past(mask_q)));

endmodule

bind clkrst_irq_regs clkrst_irq_regs_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_be       (reg_be),
  .reg_rdata    (reg_rdata),
  .evt_in       (evt_in),
  .irq_out      (irq_out),
  .sel_w        (sel_w),
  .wr_status_w  (wr_status_w),
  .wr_enable_w  (wr_enable_w),
  .wr_disable_w (wr_disable_w),
  .wdata_lo_w   (wdata_lo_w),
  .status_q     (status_q),
  .mask_q       (mask_q)
);

// File: tb/clkrst_irq_regs_bench.sv
`timescale 1ns/1ps
module clkrst_irq_regs_bench;

  localparam int ADDR_W  = 8;
  localparam int NUM_SRC = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic               reg_wr = 1'b0;
  logic [3:0]         reg_be = 4'hF;
  logic [31:0]        reg_wdata = '0;
  logic [31:0]        reg_rdata;
  logic [NUM_SRC-1:0] evt_in = '0;
  logic               irq_out;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  clkrst_irq_regs #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) u_clkrst_irq_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .evt_in    (evt_in),
    .irq_out   (irq_out)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [3:0]  evt;
    logic [7:0]  chk_addr;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h08, 4'hF, 32'h1,        4'h0, 8'h04, 32'hE, 8'd6},  // R6 unmask src0
    '{1'b0, 8'h00, 4'hF, 32'h0,        4'h3, 8'h00, 32'h3, 8'd4},  // R4 events set
    '{1'b1, 8'h00, 4'hF, 32'h1,        4'h0, 8'h00, 32'h2, 8'd3},  // R3 clear bit0
    '{1'b1, 8'h00, 4'hF, 32'h0,        4'h0, 8'h00, 32'h2, 8'd3},  // R3 zero keeps
    '{1'b1, 8'h04, 4'hF, 32'h0,        4'h0, 8'h04, 32'hE, 8'd5},  // R5 mask read-only
    '{1'b1, 8'h0C, 4'hF, 32'h1,        4'h0, 8'h04, 32'hF, 8'd7},  // R7 mask src0
    '{1'b1, 8'h08, 4'hF, 32'h6,        4'h0, 8'h04, 32'h9, 8'd6},  // R6 two bits
    '{1'b0, 8'h00, 4'hF, 32'h0,        4'h0, 8'h08, 32'h0, 8'd8},  // R8 enable reads 0
    '{1'b1, 8'h00, 4'h3, 32'h2,        4'h0, 8'h00, 32'h2, 8'd9},  // R9 partial ignored
    '{1'b1, 8'h10, 4'hF, 32'hF,        4'h0, 8'h04, 32'h9, 8'd10}, // R10 unmapped
    '{1'b1, 8'h09, 4'hF, 32'hF,        4'h0, 8'h04, 32'h9, 8'd10}, // R10 misaligned
    '{1'b1, 8'h00, 4'hF, 32'h2,        4'h2, 8'h00, 32'h2, 8'd4},  // R4 set beats clear
    '{1'b1, 8'h00, 4'hF, 32'hF,        4'h0, 8'h00, 32'h0, 8'd3},  // R3 clear all
    '{1'b0, 8'h00, 4'hF, 32'h0,        4'h0, 8'h0C, 32'h0, 8'd8},  // R8 disable reads 0
    '{1'b1, 8'h0C, 4'hF, 32'hFFFFFFFF, 4'h0, 8'h04, 32'hF, 8'd11}  // R11 upper bits 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // One bus cycle, driven at the falling edge, idle again after the rising edge.
  task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [3:0] be,
                        input logic [31:0] wdata, input logic [3:0] evt);
    @(negedge clk);
    reg_wr = wr; reg_addr = addr; reg_be = be; reg_wdata = wdata; evt_in = evt;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = 4'hF; reg_wdata = '0; evt_in = '0;
  endtask

  task automatic read_at(input logic [7:0] addr, output logic [31:0] data);
    reg_addr = addr;
    #1;
    data = reg_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_at(8'h00, rd); check("R1 status", rd, 32'h0);
    read_at(8'h04, rd); check("R1 mask", rd, 32'hF);
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      bus_op(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].wdata, VECS[i].evt);
      read_at(VECS[i].chk_addr, rd);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), rd, VECS[i].exp);
    end

    // R10 read of unmapped and misaligned addresses
    read_at(8'h10, rd); check("R10 unmapped read", rd, 32'h0);
    read_at(8'h05, rd); check("R10 misaligned read", rd, 32'h0);

    // R2 latency: state here is status 0, mask F
    bus_op(1'b1, 8'h08, 4'hF, 32'h4, 4'h0);            // unmask src2
    bus_op(1'b0, 8'h00, 4'hF, 32'h0, 4'h4);            // event on src2
    read_at(8'h00, rd); check("R4 src2 set", rd, 32'h4);
    check("R2 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    check("R2 irq rises", {31'b0, irq_out}, 32'h1);
    bus_op(1'b1, 8'h0C, 4'hF, 32'h4, 4'h0);            // mask src2
    check("R2 irq held one cycle", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R2 irq falls after mask", {31'b0, irq_out}, 32'h0);
    bus_op(1'b1, 8'h08, 4'hF, 32'h4, 4'h0);            // unmask again
    @(negedge clk);
    check("R2 irq after unmask", {31'b0, irq_out}, 32'h1);
    bus_op(1'b1, 8'h00, 4'hF, 32'h4, 4'h0);            // clear status
    check("R3 irq held one cycle", {31'b0, irq_out}, 32'h1);
    @(negedge clk);
    check("R3 irq falls after clear", {31'b0, irq_out}, 32'h0);

    // R1 reset again restores the mask
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    read_at(8'h04, rd); check("R1 mask after reset", rd, 32'hF);
    read_at(8'h00, rd); check("R1 status after reset", rd, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule